// File: doc/BRIEF.md
# Indirect Register Access Window

This block lets a narrow management port reach a wide internal register space that it cannot address directly. The management side sees a handful of 64-bit words selected by a word index. The index is the byte address shifted right by three, and every access moves one whole 8-byte word. One word holds a 12-bit pointer into the back-end space. A second word is a window: writing it sends a back-end write to the pointed location, and reading it fetches that location through a back-end read.

The back end is reached over a request channel with a valid/ready handshake and a separate response channel that carries read data and an error flag. A management access to the window stalls until the back-end response comes back. A small status word records back-end error responses and illegal management writes. Both bits are sticky, and software clears them by writing ones. Two control words accept writes and throw the data away.

Word map by index: 0 pointer, 1 window, 2 status, 3 and 4 control. Status bit 0 is the back-end error flag and bit 1 is the illegal-write flag.

Top module: `ixw_window`

## Requirements
- R1: After reset, mgmtAck and beReqValid are low, and reads of the pointer (index 0) and the status word (index 2) return zero.
- R2: A write to index 0 keeps only bits 11:0 of the written data. A read of index 0 returns those 12 bits zero-extended to 64 bits.
- R3: A write to index 1 issues exactly one back-end request with beWrite high, beAddr equal to the pointer and beWdata equal to the written word. The access is acknowledged only after the back-end response arrives.
- R4: A read of index 1 issues one back-end request with beWrite low at the pointer address. mgmtRdata equals the back-end response data, and the acknowledgement comes at least three cycles after the request is accepted.
- R5: While beReqValid is high and beReqReady is low, beReqValid stays high and beAddr and beWrite hold their values.
- R6: A write to index 2 clears every status bit whose written bit is 1 and leaves the other status bits unchanged.
- R7: A back-end response with beRspErr high sets status bit 0. The bit then stays set until software clears it through R6.
- R8: Writes to index 3 or index 4 are accepted and discarded. Reads of those indices return zero, and such writes change neither the status word nor the pointer, nor do they cause back-end traffic.
- R9: A write to any index above 4 sets status bit 1 and has no other effect. A read of any index above 4 returns zero.
- R10: An access to any index other than 1 is acknowledged with a one-cycle mgmtAck pulse in the cycle after it is accepted, and it makes no back-end request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mgmtReq | input | 1 | Management access request, held until mgmtAck |
| mgmtWrite | input | 1 | 1 = write, 0 = read |
| mgmtIndex | input | 4 | Word index (byte address >> 3) |
| mgmtWdata | input | 64 | Write data |
| mgmtAck | output | 1 | One-cycle completion pulse |
| mgmtRdata | output | 64 | Read data, valid while mgmtAck is high |
| beReqValid | output | 1 | Back-end request valid |
| beReqReady | input | 1 | Back-end request accepted |
| beWrite | output | 1 | Back-end request is a write |
| beAddr | output | 12 | Back-end register address |
| beWdata | output | 64 | Back-end write data |
| beRspValid | input | 1 | Back-end response valid (one per request) |
| beRspData | input | 64 | Back-end read data |
| beRspErr | input | 1 | Back-end error response |

## Verification
The assertions assume that the management master keeps mgmtReq and its fields steady until it sees mgmtAck, and that it drops the request in that same cycle. They also assume that the back end returns exactly one response for each request it accepts, and never before it accepts it. The bench issues every access through a single task that holds the request until the acknowledgement and drops it on that edge. The back-end model only produces a response after it has observed a handshake, with a random delay of zero to three cycles. Back-end readiness is random, and on top of that there are directed windows in which ready is held low to exercise the stall behaviour.

// File: rtl/ixw_pkg.sv
package ixw_pkg;

  localparam int unsigned IDX_PTR    = 0;
  localparam int unsigned IDX_WINDOW = 1;
  localparam int unsigned IDX_STATUS = 2;
  localparam int unsigned IDX_CTLA   = 3;
  localparam int unsigned IDX_CTLB   = 4;

  localparam int unsigned ST_BE_ERR  = 0;
  localparam int unsigned ST_BAD_WR  = 1;
  localparam int unsigned ST_WIDTH   = 2;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_ACK   = 2'd3
  } winState_t;

  typedef struct packed {
    logic accept;
    logic rspLoad;
    logic rspErr;
  } winStrobes_t;

endpackage

// File: rtl/ixw_datapath.sv
module ixw_datapath
  import ixw_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 12,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  winStrobes_t   strobes,
  input  logic          mgmtWrite,
  input  logic [IW-1:0] mgmtIndex,
  input  logic [DW-1:0] mgmtWdata,
  input  logic [DW-1:0] beRspData,
  output logic          hitWindow,
  output logic [AW-1:0] ptrReg,
  output logic [DW-1:0] wdataReg,
  output logic [DW-1:0] rdataReg,
  output logic [ST_WIDTH-1:0] statusReg
);

  logic [DW-1:0] localRead;
  logic          isPtr, isStatus, isCtl, isKnown;

  assign hitWindow = (mgmtIndex == IW'(IDX_WINDOW));
  assign isPtr     = (mgmtIndex == IW'(IDX_PTR));
  assign isStatus  = (mgmtIndex == IW'(IDX_STATUS));
  assign isCtl     = (mgmtIndex == IW'(IDX_CTLA)) || (mgmtIndex == IW'(IDX_CTLB));
  assign isKnown   = isPtr || hitWindow || isStatus || isCtl;

  always_comb begin
    localRead = '0;
    if (isPtr)         localRead[AW-1:0]       = ptrReg;
    else if (isStatus) localRead[ST_WIDTH-1:0] = statusReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg    <= '0;
      wdataReg  <= '0;
      rdataReg  <= '0;
      statusReg <= '0;
    end else begin
      if (strobes.accept) begin
        if (mgmtWrite) begin
          if (isPtr)     ptrReg    <= mgmtWdata[AW-1:0];
          if (hitWindow) wdataReg  <= mgmtWdata;
          if (isStatus)  statusReg <= statusReg & ~mgmtWdata[ST_WIDTH-1:0];
          if (!isKnown)  statusReg[ST_BAD_WR] <= 1'b1;
        end else if (!hitWindow) begin
          rdataReg <= localRead;
        end
      end
      if (strobes.rspLoad) rdataReg <= beRspData;
      if (strobes.rspErr)  statusReg[ST_BE_ERR] <= 1'b1;
    end
  end

endmodule

// File: rtl/ixw_control.sv
module ixw_control
  import ixw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mgmtReq,
  input  logic        mgmtWrite,
  input  logic        hitWindow,
  input  logic        beReqReady,
  input  logic        beRspValid,
  input  logic        beRspErr,
  output winStrobes_t strobes,
  output logic        mgmtAck,
  output logic        beReqValid,
  output logic        beWrite
);

  winState_t state, stateNext;
  logic      opWrite;

  assign strobes.accept  = (state == S_IDLE) && mgmtReq;
  assign strobes.rspLoad = (state == S_WAIT) && beRspValid && !opWrite;
  assign strobes.rspErr  = (state == S_WAIT) && beRspValid && beRspErr;

  assign mgmtAck    = (state == S_ACK);
  assign beReqValid = (state == S_ISSUE);
  assign beWrite    = opWrite;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (mgmtReq) stateNext = hitWindow ? S_ISSUE : S_ACK;
      S_ISSUE: if (beReqReady) stateNext = S_WAIT;
      S_WAIT:  if (beRspValid) stateNext = S_ACK;
      S_ACK:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.accept) opWrite <= mgmtWrite;
    end
  end

endmodule

// File: rtl/ixw_window.sv
module ixw_window
  import ixw_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 12,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mgmtReq,
  input  logic          mgmtWrite,
  input  logic [IW-1:0] mgmtIndex,
  input  logic [DW-1:0] mgmtWdata,
  output logic          mgmtAck,
  output logic [DW-1:0] mgmtRdata,
  output logic          beReqValid,
  input  logic          beReqReady,
  output logic          beWrite,
  output logic [AW-1:0] beAddr,
  output logic [DW-1:0] beWdata,
  input  logic          beRspValid,
  input  logic [DW-1:0] beRspData,
  input  logic          beRspErr
);

  winStrobes_t         strobes;
  logic                hitWindow;
  logic [ST_WIDTH-1:0] statusBits;

  ixw_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .mgmtReq    (mgmtReq),
    .mgmtWrite  (mgmtWrite),
    .hitWindow  (hitWindow),
    .beReqReady (beReqReady),
    .beRspValid (beRspValid),
    .beRspErr   (beRspErr),
    .strobes    (strobes),
    .mgmtAck    (mgmtAck),
    .beReqValid (beReqValid),
    .beWrite    (beWrite)
  );

  ixw_datapath #(.DW(DW), .AW(AW), .IW(IW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .mgmtWrite (mgmtWrite),
    .mgmtIndex (mgmtIndex),
    .mgmtWdata (mgmtWdata),
    .beRspData (beRspData),
    .hitWindow (hitWindow),
    .ptrReg    (beAddr),
    .wdataReg  (beWdata),
    .rdataReg  (mgmtRdata),
    .statusReg (statusBits)
  );

endmodule

// File: rtl/ixw_window_chk.sv
module ixw_window_chk
  import ixw_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          mgmtAck,
  input logic          mgmtWrite,
  input logic [IW-1:0] mgmtIndex,
  input logic          clrErr,
  input logic          accept,
  input logic          beReqValid,
  input logic          beReqReady,
  input logic          beWrite,
  input logic [AW-1:0] beAddr,
  input logic          errBit
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    beReqValid && !beReqReady |=> beReqValid && $stable(beAddr) && $stable(beWrite)); // R5

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    mgmtAck |=> !mgmtAck); // R10

  AST_LOCAL_FAST: assert property (@(posedge clk) disable iff (!rstN)
    accept && (mgmtIndex != IW'(IDX_WINDOW)) |=> mgmtAck && !beReqValid); // R10

  AST_WINDOW_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    accept && (mgmtIndex == IW'(IDX_WINDOW)) |=> !mgmtAck && beReqValid); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errBit && !(accept && mgmtWrite && (mgmtIndex == IW'(IDX_STATUS)) && clrErr) |=> errBit); // R7

endmodule

bind ixw_window ixw_window_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .mgmtAck    (mgmtAck),
  .mgmtWrite  (mgmtWrite),
  .mgmtIndex  (mgmtIndex),
  .clrErr     (mgmtWdata[0]),
  .accept     (strobes.accept),
  .beReqValid (beReqValid),
  .beReqReady (beReqReady),
  .beWrite    (beWrite),
  .beAddr     (beAddr),
  .errBit     (statusBits[0])
);

// File: tb/sim_ixw_window.sv
module sim_ixw_window;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mgmtReq = 1'b0, mgmtWrite = 1'b0;
  logic [3:0]  mgmtIndex = '0;
  logic [63:0] mgmtWdata = '0;
  logic        mgmtAck;
  logic [63:0] mgmtRdata;
  logic        beReqValid, beWrite;
  logic        beReqReady = 1'b0;
  logic [11:0] beAddr;
  logic [63:0] beWdata;
  logic        beRspValid = 1'b0;
  logic [63:0] beRspData = '0;
  logic        beRspErr = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  // back-end model state
  bit          hsSeen = 0, pend = 0, forceReady = 0, errInject = 0;
  int          dly = 0, rspDelay = 0, holdLeft = 0, beCount = 0;
  logic [11:0] capAddr = '0, holdAddr = '0;
  logic        capW = 1'b0;
  logic [63:0] capD = '0;
  logic [11:0] lastAddr = '0;
  logic        lastW = 1'b0;
  logic [63:0] lastD = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ixw_window u0 (
    .clk(clk), .rstN(rstN), .mgmtReq(mgmtReq), .mgmtWrite(mgmtWrite),
    .mgmtIndex(mgmtIndex), .mgmtWdata(mgmtWdata), .mgmtAck(mgmtAck),
    .mgmtRdata(mgmtRdata), .beReqValid(beReqValid), .beReqReady(beReqReady),
    .beWrite(beWrite), .beAddr(beAddr), .beWdata(beWdata),
    .beRspValid(beRspValid), .beRspData(beRspData), .beRspErr(beRspErr)
  );

  function automatic logic [63:0] beValue(input logic [11:0] a);
    return {a, 52'h0} ^ 64'h0f1e_2d3c_4b5a_6978 ^ {52'h0, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (beRspValid) beRspValid = 1'b0;
    if (hsSeen) begin
      hsSeen = 0;
      beCount++;
      lastAddr = capAddr; lastW = capW; lastD = capD;
      dly = rspDelay; pend = 1;
    end
    if (pend) begin
      if (dly == 0) begin
        beRspValid = 1'b1;
        beRspData  = lastW ? 64'h0 : beValue(lastAddr);
        beRspErr   = errInject;
        pend = 0;
      end else dly--;
    end
    beReqReady = 1'b0;
    if (beReqValid && rstN) begin
      if (holdLeft > 0) begin
        chk(beAddr == holdAddr, "R5 address held while stalled", {52'h0, beAddr}, {52'h0, holdAddr});
        holdLeft--;
      end else if (forceReady || ($urandom % 2 == 0)) begin
        beReqReady = 1'b1;
        hsSeen = 1; capAddr = beAddr; capW = beWrite; capD = beWdata;
      end
    end
  end

  task automatic access(input bit w, input int idx, input logic [63:0] wd,
                        output logic [63:0] rd, output int cyc);
    @(negedge clk);
    mgmtReq = 1'b1; mgmtWrite = w; mgmtIndex = 4'(idx); mgmtWdata = wd; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!mgmtAck && cyc < 1000);
    rd = mgmtRdata;
    mgmtReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, v;
    logic [11:0] ptrModel;
    logic [1:0]  stModel;
    int cyc, n0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(mgmtAck == 1'b0, "R1 ack low in reset", {63'h0, mgmtAck}, 64'h0);
    chk(beReqValid == 1'b0, "R1 no request in reset", {63'h0, beReqValid}, 64'h0);
    rstN = 1'b1;
    access(0, 0, 0, rd, cyc);
    chk(rd == 64'h0, "R1 pointer zero after reset", rd, 64'h0);
    access(0, 2, 0, rd, cyc);
    chk(rd == 64'h0, "R1 status zero after reset", rd, 64'h0);
    chk(cyc == 1, "R10 local access one cycle", 64'(cyc), 64'd1);

    // R2
    v = 64'hdead_beef_cafe_5a5a;
    access(1, 0, v, rd, cyc);
    access(0, 0, 0, rd, cyc);
    chk(rd == {52'h0, v[11:0]}, "R2 pointer keeps low 12 bits", rd, {52'h0, v[11:0]});
    ptrModel = v[11:0];

    // R4 window read
    forceReady = 1; n0 = beCount;
    access(0, 1, 0, rd, cyc);
    chk(rd == beValue(ptrModel), "R4 window read data", rd, beValue(ptrModel));
    chk(cyc >= 3, "R4 window read stalls", 64'(cyc), 64'd3);
    chk(beCount == n0 + 1 && lastAddr == ptrModel && lastW == 1'b0, "R4 read request", {51'h0, lastW, lastAddr}, {52'h0, ptrModel});

    // R3 window write
    v = 64'h1122_3344_5566_7788; n0 = beCount;
    access(1, 1, v, rd, cyc);
    chk(beCount == n0 + 1 && lastW == 1'b1 && lastAddr == ptrModel, "R3 write request", {51'h0, lastW, lastAddr}, {51'h1, ptrModel});
    chk(lastD == v, "R3 write data forwarded", lastD, v);
    chk(cyc >= 3, "R3 write acked after response", 64'(cyc), 64'd3);

    // R5 stall window
    forceReady = 0; holdAddr = ptrModel; holdLeft = 5; rspDelay = 2;
    access(0, 1, 0, rd, cyc);
    chk(rd == beValue(ptrModel), "R5 read after stall", rd, beValue(ptrModel));
    chk(cyc >= 8, "R5 stall lengthens access", 64'(cyc), 64'd8);
    forceReady = 1; rspDelay = 0;

    // R7 error sticky
    errInject = 1;
    access(0, 1, 0, rd, cyc);
    errInject = 0;
    access(0, 2, 0, rd, cyc);
    chk(rd == 64'h1, "R7 error bit set", rd, 64'h1);
    access(0, 1, 0, rd, cyc);
    access(0, 2, 0, rd, cyc);
    chk(rd == 64'h1, "R7 error bit sticky", rd, 64'h1);

    // R9 illegal index
    n0 = beCount;
    access(1, 7, 64'hffff, rd, cyc);
    chk(cyc == 1, "R10 illegal write acks fast", 64'(cyc), 64'd1);
    access(0, 2, 0, rd, cyc);
    chk(rd == 64'h3, "R9 illegal write flag", rd, 64'h3);
    access(0, 9, 0, rd, cyc);
    chk(rd == 64'h0, "R9 illegal read zero", rd, 64'h0);
    access(0, 0, 0, rd, cyc);
    chk(rd == {52'h0, ptrModel}, "R9 pointer untouched", rd, {52'h0, ptrModel});
    chk(beCount == n0, "R10 no back-end traffic", 64'(beCount), 64'(n0));

    // R6 W1C
    access(1, 2, 64'h2, rd, cyc);
    access(0, 2, 0, rd, cyc);
    chk(rd == 64'h1, "R6 clear only bit 1", rd, 64'h1);
    access(1, 2, 64'hffff_ffff_ffff_fffd, rd, cyc);
    access(0, 2, 0, rd, cyc);
    chk(rd == 64'h0, "R6 clear bit 0", rd, 64'h0);

    // R8 control words
    n0 = beCount;
    access(1, 3, 64'hffff_ffff_ffff_ffff, rd, cyc);
    access(1, 4, 64'h0123_4567_89ab_cdef, rd, cyc);
    access(0, 3, 0, rd, cyc);
    chk(rd == 64'h0, "R8 control A reads zero", rd, 64'h0);
    access(0, 4, 0, rd, cyc);
    chk(rd == 64'h0, "R8 control B reads zero", rd, 64'h0);
    access(0, 2, 0, rd, cyc);
    chk(rd == 64'h0, "R8 status unchanged", rd, 64'h0);
    access(0, 0, 0, rd, cyc);
    chk(rd == {52'h0, ptrModel}, "R8 pointer unchanged", rd, {52'h0, ptrModel});
    chk(beCount == n0, "R8 no back-end traffic", 64'(beCount), 64'(n0));

    // random mix
    forceReady = 0; stModel = 2'b00;
    for (int i = 0; i < 200; i++) begin
      int op;
      op = int'($urandom % 5);
      rspDelay = int'($urandom % 4);
      v = {$urandom, $urandom};
      case (op)
        0: begin access(1, 0, v, rd, cyc); ptrModel = v[11:0]; end
        1: begin
          errInject = ($urandom % 8 == 0);
          if (errInject) stModel[0] = 1'b1;
          access(0, 1, 0, rd, cyc);
          chk(rd == beValue(ptrModel), "R4 random window read", rd, beValue(ptrModel));
        end
        2: begin
          errInject = ($urandom % 8 == 0);
          if (errInject) stModel[0] = 1'b1;
          access(1, 1, v, rd, cyc);
          chk(lastW && lastAddr == ptrModel && lastD == v, "R3 random window write", lastD, v);
        end
        3: begin
          access(1, 2, v, rd, cyc);
          stModel = stModel & ~v[1:0];
        end
        default: begin
          access(0, 2, 0, rd, cyc);
          chk(rd == {62'h0, stModel}, "R6 random status", rd, {62'h0, stModel});
          access(0, 0, 0, rd, cyc);
          chk(rd == {52'h0, ptrModel}, "R2 random pointer", rd, {52'h0, ptrModel});
        end
      endcase
      errInject = 0;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule